// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-clock synchronous SRAM model. Reads and writes can follow each other in any order with no idle cycle between them. Every command is registered on a rising clock edge, together with its address, per-lane write strobes and chip selects. The data for a write comes two enabled edges later. A read's data leaves through an output register two enabled edges after its command. The write data therefore lines up on the shared data bus exactly where a read's data would sit, so the bus never has to turn around.

A load cycle takes a new address and operation. An advance cycle steps a short linear burst from the last loaded address. An active-low clock enable freezes the whole pipeline for any edge it masks. A read can reach an address whose write data has not yet landed in the array. In that case the in-flight data is merged lane by lane into the read result. The data bus is modelled as a data output plus a pad drive-enable. The drive-enable is high only when the asynchronous output enable is active and the output stage holds a selected read.

Top module: `lat_free_sram`

## Requirements
- R1: A selected read loaded or advanced on enabled edge k has its word on `dq_out` with `dq_drv` high after enabled edge k+2, provided `oe_n` is low.
- R2: The data for a selected write issued on enabled edge k is sampled from `wdata` on enabled edge k+2. The lane strobes are taken from edge k.
- R3: Reads and writes may be issued on consecutive enabled edges in any mix. A read of an address whose write data has not yet been sampled, or is being sampled on the read's following enabled edge, returns the merged new value.
- R4: In a write, `lane_wr_n[i]` low updates bits 9i+8..9i of the word (9-bit lanes, lane 0 in the low bits). A lane whose strobe is high keeps its old contents.
- R5: With `clk_en_n` high, a rising edge has no effect. Commands, write data and the output stage all keep their values, and `wdata` is not sampled.
- R6: A load cycle (`burst_adv` low) selects the device only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A deselected cycle writes nothing and leaves `dq_drv` low two enabled edges later.
- R7: An advance cycle (`burst_adv` high) ignores the selects, `wr_n` and `addr`. It repeats the operation and selection of the last load. Its address keeps the upper address bits and adds 1, modulo 4, to the two low bits on each advance. The strobes still come from the current cycle.
- R8: `dq_drv` follows `oe_n` without a clock. It is low whenever `oe_n` is high.
- R9: When the output stage holds a write, `dq_drv` is low.
- R10: Synchronous active-low `rst_n` empties the pipeline and clears the burst selection, so `dq_drv` goes low and an advance before any load is deselected. Stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_adv | input | 1 | 1 = advance burst, 0 = load new command |
| wr_n | input | 1 | 0 = write, 1 = read (load cycles) |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address (load cycles) |
| wdata | input | LANES*LANE_W | Write data, two enabled edges after its command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_drv | output | 1 | Data pad drive enable |

## Verification
The bench builds the block with its default parameters: 64 words, four 9-bit lanes and a 4-beat burst. At that depth the whole array can be preloaded. Random addresses are drawn mostly from a window of eight words, so read-after-write hits in both forwarding distances and burst wraps of the two low address bits occur often. Random clock-enable gaps land between a write command and its data, and while a read result sits in the output stage.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2
    } cmd_e;
endpackage

// File: rtl/lsr_cmd.sv
module lsr_cmd
    import lsr_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 4,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              sel_ok,
    input  logic              adv,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    output cmd_e              s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output cmd_e              s2_op,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [LANES-1:0]  s2_lanes
);
    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] cnt;
        cmd_e               bop;
        cmd_e               op1;
        logic [ADDR_W-1:0]  a1;
        logic [LANES-1:0]   l1;
        cmd_e               op2;
        logic [ADDR_W-1:0]  a2;
        logic [LANES-1:0]   l2;
    } cmd_st_t;

    cmd_st_t            st_d, st_q;
    logic [BURST_W-1:0] cnt_nx;
    logic [ADDR_W-1:0]  cur_addr;
    cmd_e               cur_op;

    always_comb begin
        st_d     = st_q;
        cnt_nx   = st_q.cnt + 1'b1;
        cur_addr = st_q.base;
        cur_addr[BURST_W-1:0] = st_q.base[BURST_W-1:0] + cnt_nx;
        cur_op   = st_q.bop;
        if (!adv) begin
            cur_addr = addr;
            cur_op   = !sel_ok ? CMD_IDLE : (wr_n ? CMD_RD : CMD_WR);
        end
        if (!cke_n) begin
            if (!adv) begin
                st_d.base = addr;
                st_d.cnt  = '0;
                st_d.bop  = cur_op;
            end else begin
                st_d.cnt  = cnt_nx;
            end
            st_d.op1 = cur_op;
            st_d.a1  = cur_addr;
            st_d.l1  = ~lane_wr_n;
            st_d.op2 = st_q.op1;
            st_d.a2  = st_q.a1;
            st_d.l2  = st_q.l1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s1_op    = st_q.op1;
    assign s1_addr  = st_q.a1;
    assign s2_op    = st_q.op2;
    assign s2_addr  = st_q.a2;
    assign s2_lanes = st_q.l2;
endmodule

// File: rtl/lsr_store.sv
module lsr_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic              fwd_hit;

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g])
                lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign fwd_hit = wr_en && wr_lanes[g] && (wr_addr == rd_addr);
        assign rd_data[g*LANE_W +: LANE_W] =
            fwd_hit ? wr_data[g*LANE_W +: LANE_W] : lane_mem[rd_addr];
    end
endmodule

// File: rtl/lsr_out.sv
module lsr_out #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              s1_rd,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              s2_rd,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drv,
    output logic              out_drive
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] dout;
        logic              drv;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!cke_n) begin
            if (s1_rd) st_d.hold = rd_data;
            st_d.dout = st_q.hold;
            st_d.drv  = s2_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dq_out    = st_q.dout;
    assign out_drive = st_q.drv;
    assign dq_drv    = st_q.drv & ~oe_n;
endmodule

// File: rtl/lat_free_sram.sv
module lat_free_sram
    import lsr_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    burst_adv,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drv
);
    localparam int DATA_W = LANES * LANE_W;

    cmd_e              s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s2_lanes;
    logic              sel_ok, s1_rd, s2_rd, s2_wr, wr_en, out_drive;
    logic [DATA_W-1:0] rd_data;

    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;
    assign s1_rd  = (s1_op == CMD_RD);
    assign s2_rd  = (s2_op == CMD_RD);
    assign s2_wr  = (s2_op == CMD_WR);
    assign wr_en  = s2_wr && !clk_en_n && rst_n;

    lsr_cmd #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cke_n(clk_en_n), .sel_ok(sel_ok),
        .adv(burst_adv), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
        .s1_op(s1_op), .s1_addr(s1_addr), .s2_op(s2_op), .s2_addr(s2_addr),
        .s2_lanes(s2_lanes)
    );

    lsr_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(s2_addr), .wr_lanes(s2_lanes),
        .wr_data(wdata), .rd_addr(s1_addr), .rd_data(rd_data)
    );

    lsr_out #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .cke_n(clk_en_n), .s1_rd(s1_rd),
        .rd_data(rd_data), .s2_rd(s2_rd), .oe_n(oe_n), .dq_out(dq_out),
        .dq_drv(dq_drv), .out_drive(out_drive)
    );
endmodule

// File: rtl/lsr_chk.sv
module lsr_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              oe_n,
    input logic              dq_drv,
    input logic [DATA_W-1:0] dq_out,
    input logic              s2_rd,
    input logic              s2_wr,
    input logic              out_drive
);
    a_r8_oe_gates_pad: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_drv);

    a_r5_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(out_drive) && $stable(dq_out)));

    a_r1_read_reaches_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s2_rd) |=> out_drive);

    a_r9_write_keeps_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s2_wr) |=> !out_drive);

    a_r6_idle_keeps_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !s2_rd && !s2_wr) |=> !out_drive);
endmodule

bind lat_free_sram lsr_chk #(.DATA_W(LANES*LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cke_n(clk_en_n), .oe_n(oe_n),
    .dq_drv(dq_drv), .dq_out(dq_out), .s2_rd(s2_rd), .s2_wr(s2_wr),
    .out_drive(out_drive)
);

// File: tb/tb_lat_free_sram.sv
module tb_lat_free_sram;
    localparam int MAXE = 8192;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        clk_en_n = 0, sel_a_n = 1, sel_b = 0, sel_c_n = 1;
    logic        burst_adv = 0, wr_n = 1, oe_n = 0;
    logic [3:0]  lane_wr_n = 4'hF;
    logic [5:0]  addr = 0;
    logic [35:0] wdata = 0;
    logic [35:0] dq_out;
    logic        dq_drv;

    lat_free_sram dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
        .sel_b(sel_b), .sel_c_n(sel_c_n), .burst_adv(burst_adv), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
        .dq_out(dq_out), .dq_drv(dq_drv)
    );

    always #5 clk = ~clk;

    int          n_chk = 0, n_bad = 0, ne = 0;
    bit          done = 0;
    int          kind [MAXE];
    logic [35:0] val  [MAXE];
    string       tg   [MAXE];
    logic [35:0] refm [64];
    string       cur_tag = "R2";
    bit          bsel = 0, bwr = 0;
    logic [5:0]  bbase = 0;
    logic [1:0]  bcnt = 0;

    function automatic logic [35:0] rnd36();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[35:0];
    endfunction

    task automatic chk_bit(input string rq, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s dq_drv actual=%0b expected=%0b", rq, act, exp);
        end
    endtask

    task automatic check_out();
        int  j;
        bit  exp_drv;
        string rq;
        j = ne - 1;
        exp_drv = (j >= 2) && (kind[j-2] == 1) && !oe_n;
        rq = "R6";
        if (j >= 2) begin
            if (kind[j-2] == 2) rq = "R9";
            else if (kind[j-2] == 1) rq = oe_n ? "R8" : tg[j-2];
        end
        chk_bit(rq, dq_drv, exp_drv);
        if (exp_drv) begin
            n_chk++;
            if (dq_out !== val[j-2]) begin
                n_bad++;
                $display("FAIL %s dq_out actual=%h expected=%h", rq, dq_out, val[j-2]);
            end
        end
    endtask

    // brk: 0 all selects active, 1..3 breaks one of them (R6)
    task automatic cyc(input bit cen, input bit adv, input int brk, input bit wrn,
                       input logic [3:0] lwn, input logic [5:0] a, input bit oen);
        logic [5:0]  ea;
        logic [35:0] d, nv;
        @(negedge clk);
        check_out();
        clk_en_n  = cen;
        burst_adv = adv;
        sel_a_n   = (brk == 1);
        sel_b     = (brk != 2);
        sel_c_n   = (brk == 3);
        wr_n      = wrn;
        lane_wr_n = lwn;
        addr      = a;
        oe_n      = oen;
        wdata     = rnd36();
        if (!cen) begin
            if (ne >= 2 && kind[ne-2] == 2) wdata = val[ne-2];
            if (!adv) begin
                bsel = (brk == 0); bbase = a; bcnt = 0; bwr = !wrn; ea = a;
            end else begin
                bcnt = bcnt + 2'd1;
                ea = {bbase[5:2], 2'(bbase[1:0] + bcnt)};
            end
            tg[ne] = cur_tag;
            if (!bsel) begin
                kind[ne] = 0;
            end else if (bwr) begin
                d  = rnd36();
                nv = refm[ea];
                for (int i = 0; i < 4; i++)
                    if (!lwn[i]) nv[i*9 +: 9] = d[i*9 +: 9];
                refm[ea] = nv;
                kind[ne] = 2;
                val[ne]  = d;
            end else begin
                kind[ne] = 1;
                val[ne]  = refm[ea];
            end
        end
        @(posedge clk);
        if (!cen) ne++;
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] lwn);
        cyc(0, 0, 0, 0, lwn, a, 0);
    endtask
    task automatic rd(input logic [5:0] a);
        cyc(0, 0, 0, 1, 4'hF, a, 0);
    endtask
    task automatic idle();
        cyc(0, 0, 2, 1, 4'hF, 6'd0, 0);
    endtask
    task automatic susp();
        cyc(1, 0, 0, 0, 4'h0, 6'($urandom()), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        check_out();
        rst_n = 0;
        clk_en_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 3; i++) begin kind[ne] = 0; ne++; end
        bsel = 0;
        n_chk++;
        if (dq_drv !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 dq_drv after reset actual=%0b expected=0", dq_drv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < MAXE; i++) kind[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: reset state
        n_chk++;
        if (dq_drv !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 dq_drv out of reset actual=%0b expected=0", dq_drv);
        end
        // R10: advance before any load is deselected, write must not land
        cur_tag = "R10";
        cyc(0, 1, 0, 0, 4'h0, 6'd0, 0);
        // R2: preload all words
        cur_tag = "R2";
        for (int a = 0; a < 64; a++) wr(6'(a), 4'h0);
        for (int a = 0; a < 4; a++) rd(6'(a));
        // R3/R4: alternating partial writes and reads, same word
        cur_tag = "R3";
        wr(6'd10, 4'b1010); rd(6'd10);
        cur_tag = "R4";
        wr(6'd10, 4'b0101); rd(6'd10);
        wr(6'd11, 4'b1110); rd(6'd10); rd(6'd11);
        cur_tag = "R3";
        wr(6'd12, 4'h0); wr(6'd12, 4'b0111); rd(6'd12); rd(6'd12);
        // R5: suspend between write command and its data, and over a read result
        cur_tag = "R5";
        wr(6'd20, 4'h0); susp(); susp(); susp(); rd(6'd20); susp(); idle();
        susp(); susp(); idle(); rd(6'd20); idle(); susp(); susp(); idle(); idle();
        // R7: bursts wrapping low bits
        cur_tag = "R7";
        wr(6'd6, 4'h0);
        cyc(0, 1, 1, 1, 4'h0, 6'd63, 0);
        cyc(0, 1, 2, 1, 4'b0011, 6'd0, 0);
        cyc(0, 1, 0, 1, 4'h0, 6'd1, 0);
        rd(6'd6);
        cyc(0, 1, 3, 0, 4'h0, 6'd9, 0);
        cyc(0, 1, 0, 0, 4'h0, 6'd9, 0);
        cyc(0, 1, 0, 0, 4'h0, 6'd9, 0);
        cyc(0, 1, 0, 0, 4'h0, 6'd9, 0);
        // R6: deselected load then advances stay idle
        cur_tag = "R6";
        cyc(0, 0, 1, 0, 4'h0, 6'd30, 0);
        cyc(0, 1, 0, 0, 4'h0, 6'd30, 0);
        cyc(0, 0, 3, 1, 4'hF, 6'd30, 0);
        rd(6'd30); idle(); idle();
        // R8: output enable off during a read result
        cur_tag = "R1";
        rd(6'd31); rd(6'd31);
        cyc(0, 0, 2, 1, 4'hF, 6'd0, 1);
        cyc(1, 0, 0, 1, 4'hF, 6'd0, 0);
        cyc(1, 0, 0, 1, 4'hF, 6'd0, 1);
        idle(); idle();
        // R10: mid-run reset keeps storage
        do_reset();
        cur_tag = "R10";
        cyc(0, 1, 0, 1, 4'hF, 6'd0, 0);
        rd(6'd10); rd(6'd20); idle(); idle();
        // random mix
        cur_tag = "R3";
        for (int n = 0; n < 2500; n++) begin
            bit          cen, adv, wrn, oen;
            int          brk;
            logic [5:0]  a;
            cen = ($urandom_range(0, 9) == 0);
            adv = ($urandom_range(0, 9) < 3);
            brk = ($urandom_range(0, 9) < 2) ? int'($urandom_range(1, 3)) : 0;
            wrn = $urandom_range(0, 1) == 1;
            oen = ($urandom_range(0, 9) == 0);
            a   = ($urandom_range(0, 3) != 0) ? 6'(8 + $urandom_range(0, 7))
                                              : 6'($urandom_range(0, 63));
            cyc(cen, adv, brk, wrn, 4'($urandom()), a, oen);
        end
        idle(); idle(); idle();
        @(negedge clk);
        check_out();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule